// File: doc/BRIEF.md
# Modem-Line Wake-Up Event Detector

This block runs on an always-on clock beside a serial port whose core clock can be switched off. It watches the four active-low modem status lines (clear-to-send, data-set-ready, ring indicator, carrier detect). It latches a per-line event bit whenever a line does something that the port would normally report as a modem status change. When the core clock is gated and at least one enabled event is latched, it asserts a wake-up request that the surrounding logic routes to the interrupt path.

An 8-bit sensitivity register, written through a small address/data port, lets software disable individual events. A status-read strobe, issued whenever the host reads the modem status register, clears the latched events. An event that lands on the same clock edge as the read is kept, so no event is lost across a clearing read. Each raw line passes through a two-flop synchronizer before edge detection. Glitches shorter than a sample period may go unseen, and this is accepted.

Top module: `modem_wake_detect`

## Requirements
- R1: A change of level in either direction on cts_n, dsr_n or dcd_n sets event_flags bit 0, 1 or 3 respectively (event bit order: 0 clear-to-send, 1 data-set-ready, 2 ring, 3 carrier detect).
- R2: On ring_n, only a low-to-high transition (the ring indicator going inactive) sets event_flags bit 2. A high-to-low transition sets nothing.
- R3: Each raw line is synchronized by two flops. A line change driven between two clock edges shows in event_flags after the third rising edge following the change, and not before.
- R4: Writing cfg_wdata with cfg_wr high and cfg_addr equal to 0x0E loads the 8-bit mask register. A set mask bit n (n = 0..3, same order as the event bits) stops event bit n from being set. The value 0x0B leaves only the ring event enabled.
- R5: Synchronous active-low reset clears event_flags and wake_req, loads the mask with 0x00 so that every event is enabled, and sets the synchronizer and edge-history stages to the inactive (high) level.
- R6: A write with cfg_addr other than 0x0E leaves the mask unchanged.
- R7: Mask bits 7:4 have no effect on event detection.
- R8: wake_req is high exactly when core_clk_gated is high and at least one event_flags bit is set. It is low whenever core_clk_gated is low.
- R9: status_rd high at a rising edge clears every event_flags bit at that edge.
- R10: An enabled event detected on the same edge as status_rd sets its bit, which stays set after the clearing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon | input | 1 | Always-on clock |
| rst_aon_n | input | 1 | Synchronous active-low reset |
| cts_n | input | 1 | Raw clear-to-send line, active low |
| dsr_n | input | 1 | Raw data-set-ready line, active low |
| ring_n | input | 1 | Raw ring indicator line, active low |
| dcd_n | input | 1 | Raw carrier detect line, active low |
| core_clk_gated | input | 1 | High while the port's core clock is switched off |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write offset |
| cfg_wdata | input | 8 | Register write data |
| status_rd | input | 1 | Modem status read strobe, clears latched events |
| wake_req | output | 1 | Wake-up request toward the interrupt path |
| event_flags | output | 4 | Latched events: 0 CTS, 1 DSR, 2 ring, 3 DCD |

## Verification
The assertions assume that status_rd and cfg_wr are single-cycle strobes sampled on clk_aon, and that after reset the raw lines rest at a defined level rather than X. They also assume that any change on a raw line reaches the event latch only through the synchronizer and edge history, so a newly set bit is always explained by a history mismatch in the previous cycle. The stimulus drives every input one time unit after a rising edge. It holds each line level for at least four edges before expecting a result, and it never toggles a line faster than the synchronizer samples it. This keeps the bench out of the accepted region where a glitch can be missed.

// File: rtl/mwu_pkg.sv
// Package: shared constants for the modem wake-up detector.
// Assumes four modem lines in the fixed event-bit order listed below.
package mwu_pkg;
    localparam int NUM_LINES  = 4;
    localparam int MASK_W     = 8;
    localparam int ADDR_W     = 4;
    localparam int SYNC_DEPTH = 2;
    localparam logic [ADDR_W-1:0] MASK_OFFSET = 4'hE;

    // Event bit positions, shared with the mask register layout.
    localparam int IDX_CTS  = 0;
    localparam int IDX_DSR  = 1;
    localparam int IDX_RING = 2;
    localparam int IDX_DCD  = 3;

    typedef logic [NUM_LINES-1:0] line_vec_t;
endpackage

// File: rtl/mwu_sync_bank.sv
// Module: mwu_sync_bank
// Brings WIDTH asynchronous lines into the clock domain with a chain of
// STAGES flops per line. Assumes the lines are quasi-static compared with
// the clock; narrower pulses may be lost. Reset loads RST_VAL into every stage.
module mwu_sync_bank #(
    parameter int WIDTH   = 4,
    parameter int STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage captures the raw lines.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= {WIDTH{RST_VAL}};
        else        stage_q[0] <= async_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage re-samples the one before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= {WIDTH{RST_VAL}};
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/mwu_event_detect.sv
// Module: mwu_event_detect
// Compares each synchronized line with its value one cycle earlier.
// The ring line reports only its low-to-high (indicator inactive) edge.
// Other lines report any change. Assumes active-low lines at rest high after reset.
module mwu_event_detect
    import mwu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t cur_lvl,
    output line_vec_t prev_lvl,
    output line_vec_t raw_ev
);
    line_vec_t prev_q;

    // Edge history: last synchronized level of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= cur_lvl;
    end

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            if (i == IDX_RING) begin : g_trailing
                // Ring reports only the pin rising back to inactive.
                assign raw_ev[i] = ~prev_q[i] & cur_lvl[i];
            end else begin : g_delta
                // Other lines report any level change.
                assign raw_ev[i] = prev_q[i] ^ cur_lvl[i];
            end
        end
    endgenerate

    assign prev_lvl = prev_q;
endmodule

// File: rtl/mwu_mask_reg.sv
// Module: mwu_mask_reg
// Holds the event disable mask, written when the offset matches.
// Only the low NUM_LINES bits steer detection; the rest are plain storage.
module mwu_mask_reg
    import mwu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [MASK_W-1:0] wr_data,
    output logic [MASK_W-1:0] mask,
    output line_vec_t         ev_enable
);
    logic [MASK_W-1:0] mask_q;
    logic              hit;

    // Address decode for the single register of this block.
    assign hit = wr_en && (wr_addr == MASK_OFFSET);

    // Mask storage, cleared so every event is enabled after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask_q <= '0;
        else if (hit) mask_q <= wr_data;
    end

    assign mask      = mask_q;
    assign ev_enable = ~mask_q[NUM_LINES-1:0];
endmodule

// File: rtl/mwu_event_latch.sv
// Module: mwu_event_latch
// Accumulates enabled events until a status read clears them. An event on
// the clearing edge wins. The wake request is gated by the core-clock-off indication.
module mwu_event_latch
    import mwu_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  line_vec_t raw_ev,
    input  line_vec_t ev_enable,
    input  logic      clr,
    input  logic      gated,
    output line_vec_t flags,
    output logic      wake
);
    line_vec_t flags_q;
    line_vec_t kept;

    // Bits that survive this edge: none on a read, otherwise all.
    assign kept = clr ? '0 : flags_q;

    // Sticky event storage with new events taking priority over the clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= kept | (raw_ev & ev_enable);
    end

    assign flags = flags_q;
    assign wake  = gated & (|flags_q);
endmodule

// File: rtl/modem_wake_detect.sv
// Module: modem_wake_detect (top)
// Wake-up event detector for a serial port whose core clock may be gated.
// Assumes clk_aon is free-running and status_rd / cfg_wr are one-cycle strobes.
module modem_wake_detect
    import mwu_pkg::*;
(
    input  logic              clk_aon,
    input  logic              rst_aon_n,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ring_n,
    input  logic              dcd_n,
    input  logic              core_clk_gated,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [MASK_W-1:0] cfg_wdata,
    input  logic              status_rd,
    output logic              wake_req,
    output logic [NUM_LINES-1:0] event_flags
);
    line_vec_t         raw_lines;
    line_vec_t         sync_q;
    line_vec_t         prev_q;
    line_vec_t         raw_ev;
    line_vec_t         ev_en;
    logic [MASK_W-1:0] mask_q;

    // Pack lines in event-bit order.
    assign raw_lines = {dcd_n, ring_n, dsr_n, cts_n};

    mwu_sync_bank #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(1'b1)
    ) u_sync (
        .clk     (clk_aon),
        .rst_n   (rst_aon_n),
        .async_in(raw_lines),
        .sync_out(sync_q)
    );

    mwu_event_detect u_detect (
        .clk     (clk_aon),
        .rst_n   (rst_aon_n),
        .cur_lvl (sync_q),
        .prev_lvl(prev_q),
        .raw_ev  (raw_ev)
    );

    mwu_mask_reg u_mask (
        .clk      (clk_aon),
        .rst_n    (rst_aon_n),
        .wr_en    (cfg_wr),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .mask     (mask_q),
        .ev_enable(ev_en)
    );

    mwu_event_latch u_latch (
        .clk      (clk_aon),
        .rst_n    (rst_aon_n),
        .raw_ev   (raw_ev),
        .ev_enable(ev_en),
        .clr      (status_rd),
        .gated    (core_clk_gated),
        .flags    (event_flags),
        .wake     (wake_req)
    );
endmodule

// File: rtl/modem_wake_detect_chk.sv
// Checker for modem_wake_detect, attached by bind below.
module modem_wake_detect_chk
    import mwu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [MASK_W-1:0] cfg_wdata,
    input logic              status_rd,
    input logic              core_clk_gated,
    input logic              wake_req,
    input logic [NUM_LINES-1:0] event_flags,
    input logic [NUM_LINES-1:0] sync_q,
    input logic [NUM_LINES-1:0] prev_q,
    input logic [NUM_LINES-1:0] raw_ev,
    input logic [MASK_W-1:0] mask_q
);
    // R5: reset leaves no latched event and no wake request.
    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |=> (event_flags == '0) && !wake_req);

    // R8: no wake request while the core clock runs.
    p_wake_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !core_clk_gated |-> !wake_req);

    // R8: a latched event with gated clock raises the request.
    p_wake_on_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_clk_gated && (event_flags != '0)) |-> wake_req);

    // R9: after a read only bits for events detected at that edge remain.
    p_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> ((event_flags & ~$past(raw_ev)) == '0));

    // R1: a newly set bit needs a history mismatch one cycle earlier.
    p_set_needs_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flags & ~$past(event_flags) & ~$past(sync_q ^ prev_q)) == '0);

    // R4: a masked event never sets its bit.
    p_mask_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (event_flags & ~$past(event_flags) & $past(mask_q[NUM_LINES-1:0])) == '0);

    // R4: a matching write loads the mask.
    p_mask_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == MASK_OFFSET) |=> mask_q == $past(cfg_wdata));

    // R6: a non-matching write leaves the mask alone.
    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr != MASK_OFFSET) |=> $stable(mask_q));
endmodule

bind modem_wake_detect modem_wake_detect_chk u_chk (
    .clk           (clk_aon),
    .rst_n         (rst_aon_n),
    .cfg_wr        (cfg_wr),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .status_rd     (status_rd),
    .core_clk_gated(core_clk_gated),
    .wake_req      (wake_req),
    .event_flags   (event_flags),
    .sync_q        (sync_q),
    .prev_q        (prev_q),
    .raw_ev        (raw_ev),
    .mask_q        (mask_q)
);

// File: tb/modem_wake_detect_tb_top.sv
// Bench for modem_wake_detect: vector table walk, then directed corner tests.
module modem_wake_detect_tb_top;
    logic       clk_aon = 1'b0;
    logic       rst_aon_n = 1'b0;
    logic [3:0] ln = 4'hF;          // {dcd_n, ring_n, dsr_n, cts_n}
    logic       core_clk_gated = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = 4'h0;
    logic [7:0] cfg_wdata = 8'h00;
    logic       status_rd = 1'b0;
    logic       wake_req;
    logic [3:0] event_flags;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk_aon = ~clk_aon;   // 50 MHz

    modem_wake_detect dut_i (
        .clk_aon       (clk_aon),
        .rst_aon_n     (rst_aon_n),
        .cts_n         (ln[0]),
        .dsr_n         (ln[1]),
        .ring_n        (ln[2]),
        .dcd_n         (ln[3]),
        .core_clk_gated(core_clk_gated),
        .cfg_wr        (cfg_wr),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .status_rd     (status_rd),
        .wake_req      (wake_req),
        .event_flags   (event_flags)
    );

    // Vector fields: [10:7] lines, [6] gated, [5] read, [4:1] flags, [0] wake.
    localparam int NV = 11;
    localparam logic [10:0] VEC [NV] = '{
        {4'b1111, 1'b0, 1'b0, 4'b0000, 1'b0},  // idle        R5
        {4'b1110, 1'b0, 1'b0, 4'b0001, 1'b0},  // cts low     R1 R8
        {4'b1110, 1'b1, 1'b0, 4'b0001, 1'b1},  // gate        R8
        {4'b1110, 1'b1, 1'b1, 4'b0000, 1'b0},  // read        R9
        {4'b1100, 1'b1, 1'b0, 4'b0010, 1'b1},  // dsr low     R1
        {4'b1000, 1'b1, 1'b1, 4'b0000, 1'b0},  // ring assert R2
        {4'b1100, 1'b1, 1'b0, 4'b0100, 1'b1},  // ring release R2
        {4'b0100, 1'b1, 1'b1, 4'b1000, 1'b1},  // dcd low     R1 R10
        {4'b0101, 1'b1, 1'b0, 4'b1001, 1'b1},  // cts high    R1
        {4'b1111, 1'b0, 1'b1, 4'b1010, 1'b0},  // dsr,dcd up  R1 R8
        {4'b1111, 1'b0, 1'b1, 4'b0000, 1'b0}   // clear       R9
    };

    task automatic step(input int n);
        for (int k = 0; k < n; k++) begin
            @(posedge clk_aon);
            #1;
        end
    endtask

    task automatic check(input string req, input logic [3:0] ef, input logic ew);
        n_vec++;
        if (event_flags !== ef || wake_req !== ew) begin
            n_fail++;
            $display("FAIL %s: flags=%b wake=%b expected flags=%b wake=%b",
                     req, event_flags, wake_req, ef, ew);
        end
    endtask

    task automatic wr_mask(input logic [3:0] a, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        step(1);
        cfg_wr = 1'b0;
    endtask

    task automatic clear_read();
        status_rd = 1'b1;
        step(1);
        status_rd = 1'b0;
    endtask

    initial begin
        step(3);
        rst_aon_n = 1'b1;
        step(1);
        check("R5 reset state", 4'b0000, 1'b0);

        // Table walk: read pulse on first edge, events land on third.
        for (int v = 0; v < NV; v++) begin
            ln             = VEC[v][10:7];
            core_clk_gated = VEC[v][6];
            status_rd      = VEC[v][5];
            step(1);
            status_rd      = 1'b0;
            step(3);
            check($sformatf("R1/R2/R8/R9 vector %0d", v), VEC[v][4:1], VEC[v][0]);
        end

        // R6: write at the wrong offset is ignored; cts still latches.
        wr_mask(4'hD, 8'hFF);
        ln[0] = 1'b0;
        step(4);
        check("R6 foreign offset", 4'b0001, 1'b0);
        clear_read();

        // R4: 0x0B keeps only ring.
        wr_mask(4'hE, 8'h0B);
        ln = 4'b0101;                       // cts up, dsr low, dcd low
        step(4);
        check("R4 masked lines", 4'b0000, 1'b0);
        ln[2] = 1'b0;
        step(4);
        check("R4 ring assert masked-in but not an event", 4'b0000, 1'b0);
        ln[2] = 1'b1;
        step(4);
        core_clk_gated = 1'b1;
        #1;
        check("R4 R2 ring release", 4'b0100, 1'b1);
        core_clk_gated = 1'b0;
        #1;
        check("R8 ungated", 4'b0100, 1'b0);
        clear_read();

        // R7: only upper bits set, all events enabled.
        wr_mask(4'hE, 8'hF0);
        ln[0] = 1'b0;
        step(4);
        check("R7 upper mask bits", 4'b0001, 1'b0);

        // R3 / R10: dsr change meets a read on its latching edge.
        ln[1] = 1'b1;
        step(2);
        check("R3 not before third edge", 4'b0001, 1'b0);
        status_rd = 1'b1;
        step(1);
        status_rd = 1'b0;
        check("R10 event survives read", 4'b0010, 1'b0);

        // R5: reset mid-run clears flags and mask.
        wr_mask(4'hE, 8'h0F);
        ln = 4'hF;
        rst_aon_n = 1'b0;
        step(2);
        check("R5 flags cleared by reset", 4'b0000, 1'b0);
        rst_aon_n = 1'b1;
        step(2);
        ln[3] = 1'b0;
        step(4);
        check("R5 mask reset enables dcd", 4'b1000, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule